// File: doc/BRIEF.md
# Three-Stage Pipeline Stall Controller

This block sequences a fetch / decode / execute pipeline whose instructions and data share one memory. Each cycle it decides whether the program counter moves on (the PC itself, which steps by 2 per 16-bit instruction in a byte-addressed memory, lives outside), whether the two pipeline registers load, and whether the word arriving from memory is parked in a holding register. It owns the decode instruction register and the holding register, so the word that reaches decode is visible at its ports.

A memory that is not ready freezes the PC and both pipeline registers, and the same fetch repeats. A load or store spends two cycles in execute. In the first, the word being fetched is parked and the pipeline holds. In the second, memory serves the data access, so nothing is fetched. When that access completes, the parked word enters decode and fetch resumes. A taken jump in execute loads the PC with the target and replaces the stale words behind it with a bubble. A small compare unit raises forwarding selects when a decode operand names the register that execute is writing.

Top module: `pipe_stall_ctrl`

## Requirements
- R1: After reset the decode register holds the bubble word (parameter NOP, default 16'h0000), the holding register is empty (`dc_sel_tmp` = 0) and the controller is in its normal state.
- R2: With `mem_rdy` high and neither `ex_ldst` nor `ex_jump_taken` set, `pc_en` and `pipe_en` are 1, `tmp_en` is 0, and the decode register takes `fetch_word` at the clock edge.
- R3: With `mem_rdy` low and no taken jump, `pc_en` and `pipe_en` are 0 and the decode register keeps its value.
- R4: In the first execute cycle of a load/store (`ex_ldst` high, normal state) with `mem_rdy` high, `tmp_en` and `pc_en` are 1, `pipe_en` is 0, and the decode register keeps its value.
- R5: In the second execute cycle of a load/store, `pc_en` is 0, `dc_sel_tmp` is 1 and `pipe_en` equals `mem_rdy`; the controller stays in this cycle while `mem_rdy` is low.
- R6: When the second load/store cycle completes, the decode register takes the parked word, not `fetch_word`; in the next cycle `dc_sel_tmp` is 0 and fetch proceeds as in R2.
- R7: A taken jump (`ex_jump_taken` high, `ex_ldst` low) sets `pc_en`, `pc_jump_sel`, `pipe_en` and `flush` to 1 whatever `mem_rdy` is, and the decode register becomes the bubble word.
- R8: `ex_jump_taken` is ignored while `ex_ldst` is high: `flush` and `pc_jump_sel` stay 0.
- R9: `fwd_a` (`fwd_b`) is 1 exactly when `ex_wr` is 1 and `ex_rd` equals `dc_rs_a` (`dc_rs_b`).
- R10: In the first load/store execute cycle with `mem_rdy` low, nothing is parked (`tmp_en` = 0), `pc_en` and `pipe_en` are 0, and the cycle repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mem_rdy | input | 1 | Shared memory completes the current access this cycle |
| ex_ldst | input | 1 | Instruction in execute is a load or store |
| ex_jump_taken | input | 1 | Instruction in execute is a jump that is taken |
| fetch_word | input | IW | Instruction word read from memory |
| ex_wr | input | 1 | Execute stage writes a register |
| ex_rd | input | RW | Register written by execute |
| dc_rs_a | input | RW | First source register read in decode |
| dc_rs_b | input | RW | Second source register read in decode |
| pc_en | output | 1 | Program counter update enable |
| pc_jump_sel | output | 1 | PC loads the jump target instead of PC+2 |
| pipe_en | output | 1 | Load enable of both pipeline registers |
| tmp_en | output | 1 | Holding register captures `fetch_word` |
| dc_sel_tmp | output | 1 | Decode register input comes from the holding register |
| flush | output | 1 | Pipeline registers take a bubble |
| dc_instr | output | IW | Decode instruction register |
| fwd_a | output | 1 | Forward execute result to the first operand |
| fwd_b | output | 1 | Forward execute result to the second operand |

## Verification
A wrong stage state shows up in the same cycle on `pc_en` and `dc_sel_tmp`: a controller stuck in the second load/store cycle keeps the PC frozen, while one that skips it lets the PC move during the data access. A lost or stale valid bit shows one edge later as the wrong word in `dc_instr`, either the live fetch word in place of the parked one or an old word replayed twice. A missed flush shows one edge after the jump as a non-bubble word in decode.

// File: rtl/pipe_stall_pkg.sv
package pipe_stall_pkg;
  typedef enum logic {
    ST_RUN = 1'b0,
    ST_LS2 = 1'b1
  } stage_e;
endpackage

// File: rtl/pipe_stall_fsm.sv
module pipe_stall_fsm
  import pipe_stall_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mem_rdy,
  input  logic ex_ldst,
  input  logic ex_jump_taken,
  output logic pc_en,
  output logic pc_jump_sel,
  output logic pipe_en,
  output logic tmp_en,
  output logic flush
);
  stage_e st_q, st_d;
  logic   jump_go;

  assign jump_go = ex_jump_taken & ~ex_ldst;

  always_comb begin
    st_d        = st_q;
    pc_en       = 1'b0;
    pc_jump_sel = 1'b0;
    pipe_en     = 1'b0;
    tmp_en      = 1'b0;
    flush       = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        if (jump_go) begin
          pc_en       = 1'b1;
          pc_jump_sel = 1'b1;
          pipe_en     = 1'b1;
          flush       = 1'b1;
        end else if (ex_ldst) begin
          pc_en  = mem_rdy;
          tmp_en = mem_rdy;
          if (mem_rdy) st_d = ST_LS2;
        end else begin
          pc_en   = mem_rdy;
          pipe_en = mem_rdy;
        end
      end
      ST_LS2: begin
        pipe_en = mem_rdy;
        if (mem_rdy) st_d = ST_RUN;
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_RUN;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/pipe_park_reg.sv
module pipe_park_reg #(
  parameter int            IW  = 16,
  parameter logic [IW-1:0] NOP = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] fetch_word,
  input  logic          tmp_en,
  input  logic          pipe_en,
  input  logic          flush,
  output logic [IW-1:0] dc_instr,
  output logic          dc_sel_tmp
);
  logic [IW-1:0] tmp_q;
  logic          tmp_vld_q, tmp_vld_d;
  logic [IW-1:0] dc_d;

  assign dc_sel_tmp = tmp_vld_q;

  always_comb begin
    tmp_vld_d = tmp_vld_q;
    if (tmp_en)                    tmp_vld_d = 1'b1;
    else if (pipe_en && tmp_vld_q) tmp_vld_d = 1'b0;
    if (flush)          dc_d = NOP;
    else if (tmp_vld_q) dc_d = tmp_q;
    else                dc_d = fetch_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmp_vld_q <= 1'b0;
      tmp_q     <= NOP;
      dc_instr  <= NOP;
    end else begin
      tmp_vld_q <= tmp_vld_d;
      if (tmp_en)  tmp_q    <= fetch_word;
      if (pipe_en) dc_instr <= dc_d;
    end
  end
endmodule

// File: rtl/pipe_fwd_cmp.sv
module pipe_fwd_cmp #(
  parameter int RW    = 4,
  parameter int NSRC  = 2
) (
  input  logic                    ex_wr,
  input  logic [RW-1:0]           ex_rd,
  input  logic [NSRC-1:0][RW-1:0] rs,
  output logic [NSRC-1:0]         fwd
);
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign fwd[g] = ex_wr && (ex_rd == rs[g]);
  end
endmodule

// File: rtl/pipe_stall_ctrl.sv
module pipe_stall_ctrl #(
  parameter int            IW  = 16,
  parameter int            RW  = 4,
  parameter logic [IW-1:0] NOP = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mem_rdy,
  input  logic          ex_ldst,
  input  logic          ex_jump_taken,
  input  logic [IW-1:0] fetch_word,
  input  logic          ex_wr,
  input  logic [RW-1:0] ex_rd,
  input  logic [RW-1:0] dc_rs_a,
  input  logic [RW-1:0] dc_rs_b,
  output logic          pc_en,
  output logic          pc_jump_sel,
  output logic          pipe_en,
  output logic          tmp_en,
  output logic          dc_sel_tmp,
  output logic          flush,
  output logic [IW-1:0] dc_instr,
  output logic          fwd_a,
  output logic          fwd_b
);
  localparam int NSRC = 2;

  logic [NSRC-1:0][RW-1:0] src_regs;
  logic [NSRC-1:0]         fwd_vec;

  assign src_regs = {dc_rs_b, dc_rs_a};
  assign fwd_a    = fwd_vec[0];
  assign fwd_b    = fwd_vec[1];

  pipe_stall_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .mem_rdy(mem_rdy), .ex_ldst(ex_ldst),
    .ex_jump_taken(ex_jump_taken), .pc_en(pc_en), .pc_jump_sel(pc_jump_sel),
    .pipe_en(pipe_en), .tmp_en(tmp_en), .flush(flush)
  );

  pipe_park_reg #(.IW(IW), .NOP(NOP)) u_park (
    .clk(clk), .rst_n(rst_n), .fetch_word(fetch_word), .tmp_en(tmp_en),
    .pipe_en(pipe_en), .flush(flush), .dc_instr(dc_instr), .dc_sel_tmp(dc_sel_tmp)
  );

  pipe_fwd_cmp #(.RW(RW), .NSRC(NSRC)) u_fwd (
    .ex_wr(ex_wr), .ex_rd(ex_rd), .rs(src_regs), .fwd(fwd_vec)
  );
endmodule

// File: rtl/pipe_stall_chk.sv
module pipe_stall_chk #(
  parameter int            IW  = 16,
  parameter logic [IW-1:0] NOP = '0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_rdy,
  input logic          ex_ldst,
  input logic          ex_jump_taken,
  input logic          pc_en,
  input logic          pc_jump_sel,
  input logic          pipe_en,
  input logic          tmp_en,
  input logic          dc_sel_tmp,
  input logic          flush,
  input logic [IW-1:0] dc_instr
);
  // R3 and R10: no movement while memory is busy, unless a jump redirects
  assert_busy_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rdy && !flush) |-> (!pc_en && !pipe_en));

  // R4: parking never coincides with a pipeline load
  assert_park_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tmp_en |-> (!pipe_en && pc_en));

  // R5: the cycle after parking fetches nothing and selects the holding register
  assert_ls2_nofetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tmp_en) && $past(rst_n)) |-> (!pc_en && dc_sel_tmp));

  // R7: a taken jump redirects and flushes
  assert_jump_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_jump_taken && !ex_ldst && !dc_sel_tmp) |-> (flush && pc_jump_sel && pc_en && pipe_en));

  assert_bubble_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flush) && $past(rst_n)) |-> (dc_instr == NOP));

  // R8: load/store masks the jump
  assert_ldst_masks_jump_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ex_ldst |-> (!flush && !pc_jump_sel));

  assert_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tmp_en, flush}));
endmodule

bind pipe_stall_ctrl pipe_stall_chk #(.IW(IW), .NOP(NOP)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rdy(mem_rdy), .ex_ldst(ex_ldst),
  .ex_jump_taken(ex_jump_taken), .pc_en(pc_en), .pc_jump_sel(pc_jump_sel),
  .pipe_en(pipe_en), .tmp_en(tmp_en), .dc_sel_tmp(dc_sel_tmp), .flush(flush),
  .dc_instr(dc_instr)
);

// File: tb/pipe_stall_ctrl_tb.sv
module pipe_stall_ctrl_tb;
  localparam int IW = 16;
  localparam int RW = 4;
  localparam logic [IW-1:0] NOP = 16'h0000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mem_rdy = 1'b0, ex_ldst = 1'b0, ex_jump_taken = 1'b0;
  logic [IW-1:0] fetch_word = '0;
  logic          ex_wr = 1'b0;
  logic [RW-1:0] ex_rd = '0, dc_rs_a = '0, dc_rs_b = '0;
  logic          pc_en, pc_jump_sel, pipe_en, tmp_en, dc_sel_tmp, flush, fwd_a, fwd_b;
  logic [IW-1:0] dc_instr;

  int n_chk = 0;
  int n_fail = 0;
  logic [IW-1:0] exp_q[$];
  string         tag_q[$];

  always #10 clk = ~clk;

  pipe_stall_ctrl #(.IW(IW), .RW(RW), .NOP(NOP)) u_dut (
    .clk(clk), .rst_n(rst_n), .mem_rdy(mem_rdy), .ex_ldst(ex_ldst),
    .ex_jump_taken(ex_jump_taken), .fetch_word(fetch_word), .ex_wr(ex_wr),
    .ex_rd(ex_rd), .dc_rs_a(dc_rs_a), .dc_rs_b(dc_rs_b), .pc_en(pc_en),
    .pc_jump_sel(pc_jump_sel), .pipe_en(pipe_en), .tmp_en(tmp_en),
    .dc_sel_tmp(dc_sel_tmp), .flush(flush), .dc_instr(dc_instr),
    .fwd_a(fwd_a), .fwd_b(fwd_b)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus, checks the control outputs, and
  // queues the decode register value expected after the next edge.
  task automatic cyc(input string req, input logic rdy, input logic ls, input logic jp,
                     input logic [IW-1:0] w, input logic e_pc, input logic e_pipe,
                     input logic e_tmp, input logic e_sel, input logic e_fl,
                     input logic [IW-1:0] e_dc);
    @(negedge clk);
    mem_rdy = rdy; ex_ldst = ls; ex_jump_taken = jp; fetch_word = w;
    #1;
    chk({req, " ctl"}, {pc_en, pipe_en, tmp_en, dc_sel_tmp, flush, pc_jump_sel},
        {e_pc, e_pipe, e_tmp, e_sel, e_fl, e_fl});
    exp_q.push_back(e_dc);
    tag_q.push_back(req);
  endtask

  // Monitor: compares the decode register after each edge.
  always @(posedge clk) begin
    #5;
    if (exp_q.size() > 0) begin
      automatic logic [IW-1:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk({t, " dc_instr"}, {16'h0, dc_instr}, {16'h0, e});
    end
  end

  task automatic fchk(input logic wr, input logic [RW-1:0] rd, input logic [RW-1:0] ra,
                      input logic [RW-1:0] rb, input logic ea, input logic eb);
    ex_wr = wr; ex_rd = rd; dc_rs_a = ra; dc_rs_b = rb;
    #1;
    chk("R9 forward", {fwd_a, fwd_b}, {ea, eb});
  endtask

  initial begin
    #(20 * 5000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset dc", {16'h0, dc_instr}, {16'h0, NOP});
    chk("R1 reset sel", dc_sel_tmp, 1'b0);
    rst_n = 1'b1;
    //        req   rdy ls jp word      pc pipe tmp sel fl dc
    cyc("R2",       1, 0, 0, 16'hA001, 1, 1, 0, 0, 0, 16'hA001);
    cyc("R2",       1, 0, 0, 16'hA002, 1, 1, 0, 0, 0, 16'hA002);
    cyc("R3",       0, 0, 0, 16'hDEAD, 0, 0, 0, 0, 0, 16'hA002);
    cyc("R2",       1, 0, 0, 16'hA003, 1, 1, 0, 0, 0, 16'hA003);
    cyc("R4",       1, 1, 0, 16'h7001, 1, 0, 1, 0, 0, 16'hA003);
    cyc("R5 wait",  0, 1, 0, 16'hBAD1, 0, 0, 0, 1, 0, 16'hA003);
    cyc("R5 done",  1, 1, 0, 16'hBAD2, 0, 1, 0, 1, 0, 16'h7001);
    cyc("R6",       1, 0, 0, 16'hB001, 1, 1, 0, 0, 0, 16'hB001);
    cyc("R10",      0, 1, 0, 16'hBAD3, 0, 0, 0, 0, 0, 16'hB001);
    cyc("R8",       1, 1, 1, 16'h7002, 1, 0, 1, 0, 0, 16'hB001);
    cyc("R5 R6",    1, 1, 1, 16'hBAD4, 0, 1, 0, 1, 0, 16'h7002);
    cyc("R7 busy",  0, 0, 1, 16'hC0DE, 1, 1, 0, 0, 1, NOP);
    cyc("R2",       1, 0, 0, 16'hC001, 1, 1, 0, 0, 0, 16'hC001);
    cyc("R7",       1, 0, 1, 16'hC002, 1, 1, 0, 0, 1, NOP);
    cyc("R2",       1, 0, 0, 16'hC003, 1, 1, 0, 0, 0, 16'hC003);
    @(negedge clk);
    mem_rdy = 1'b0; ex_jump_taken = 1'b0; ex_ldst = 1'b0;
    #2;
    fchk(1, 4'd5, 4'd5, 4'd3, 1, 0);
    fchk(0, 4'd5, 4'd5, 4'd5, 0, 0);
    fchk(1, 4'd3, 4'd3, 4'd3, 1, 1);
    fchk(1, 4'd9, 4'd2, 4'd9, 0, 1);
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule